// File: doc/BRIEF.md
# NAND Flash Bus Cycle Front End

This block sits on the device side of an 8-bit asynchronous NAND flash bus. It watches five control pins: a select, a command latch, an address latch, a write strobe and a read strobe. Each pin passes through a small clock-domain synchroniser. On each rising edge of the write strobe, the block sorts the cycle into one of four kinds: command, address, data input, or an illegal combination. It uses only the levels of the other pins at that moment to decide.

Command bytes are latched and announced to internal logic with a one-clock strobe. Address bytes are gathered into a wide word, lowest byte first. When the last address byte arrives, a column is loaded into the write pointer and into the read pointer of a small page buffer. Program data is pushed into the page buffer one byte per write strobe, and each byte is also announced to internal logic. While the bus is in a read cycle, the byte at the read column is driven out, and each rising edge of the read strobe moves to the next byte.

The bus pins are asynchronous to the system clock. Every pin level is expected to stay stable for at least four system clocks. The I/O output is given as a data vector plus an enable, so that a pad-level three-state buffer can be placed outside the block.

Top module: `nand_cycle_front`

## Requirements
- R1: When the write strobe rises while bus_sel_n=0, bus_cmd_lat=1, bus_adr_lat=0 and bus_rstb_n=1, cmd_byte takes io_in and cmd_stb pulses high for exactly one clock.
- R2: When the write strobe rises while bus_sel_n=0, bus_adr_lat=1, bus_cmd_lat=0 and bus_rstb_n=1, io_in is stored as the next address byte.
- R3: Address byte k (k = 0..3, counted from the last command) lands in addr_word bits [8k+7:8k]. addr_done pulses for one clock after the fourth byte.
- R4: Address bytes after the fourth are ignored until the next command; addr_word does not change.
- R5: A command cycle clears addr_word to zero and restarts the address byte count at byte 0.
- R6: When the write strobe rises while bus_sel_n=0, both latch pins are 0 and bus_rstb_n=1, wr_data takes io_in and wr_stb pulses for one clock. The byte is also written to the page buffer at the write column, and the write column then advances by one.
- R7: When the address phase completes, the write column and the read column are both set to {byte1,byte0} modulo PAGE_BYTES. While the read strobe is low in a read cycle, io_out shows the page byte at the read column. Each rising edge of the read strobe advances the read column by one.
- R8: io_oe is 1 only when bus_sel_n=0, bus_wstb_n=1, both latch pins are 0 and bus_rstb_n=0. It follows a pin change within three clocks. In every other case, io_oe is 0.
- R9: Both columns wrap from PAGE_BYTES-1 to 0.
- R10: A write strobe rise with both latch pins high changes neither cmd_byte, addr_word nor the page buffer, and raises no strobe. It sets bus_err, which stays 1 until reset.
- R11: A write strobe rise while bus_sel_n=1 is ignored: no strobe is raised and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Bus select, active low |
| bus_cmd_lat | input | 1 | Command latch pin, active high |
| bus_adr_lat | input | 1 | Address latch pin, active high |
| bus_wstb_n | input | 1 | Write strobe, bytes captured on its rising edge |
| bus_rstb_n | input | 1 | Read strobe, active low |
| io_in | input | 8 | Byte arriving from the bus |
| io_out | output | 8 | Byte to drive onto the bus |
| io_oe | output | 1 | Enable for the external bus driver |
| cmd_byte | output | 8 | Most recent command byte |
| cmd_stb | output | 1 | One-clock pulse when a new command is latched |
| addr_word | output | 32 | Assembled address |
| addr_done | output | 1 | One-clock pulse when the last address byte has arrived |
| wr_data | output | 8 | Most recent program data byte |
| wr_stb | output | 1 | One-clock pulse when a new data byte arrives |
| bus_err | output | 1 | Sticky flag for an illegal latch combination |

## Verification
A pin change passes two synchroniser flops and one edge or decode register. So cmd_stb, addr_done, wr_stb and the registers behind them change on the third clock edge after a write strobe rises, and io_oe and io_out settle on the third edge after the read strobe falls.

The bench holds every pin level for at least four clocks. It reads registered results five clocks after the triggering pin change, on the falling clock edge. It counts the one-clock strobes with a monitor that runs on every rising edge, so a pulse is never missed between sample points.

// File: rtl/nand_cycle_pkg.sv
package nand_cycle_pkg;

   typedef enum logic [2:0] {
      CYC_NONE,
      CYC_CMD,
      CYC_ADDR,
      CYC_DIN,
      CYC_BAD
   } cyc_kind_t;

   // Sort a write-type bus cycle by pin levels seen at the write strobe rise.
   function automatic cyc_kind_t classify(input logic sel_n, input logic cl,
                                          input logic al, input logic rs_n);
      if (sel_n || !rs_n) return CYC_NONE;
      if (cl && al)       return CYC_BAD;
      if (cl)             return CYC_CMD;
      if (al)             return CYC_ADDR;
      return CYC_DIN;
   endfunction

endpackage

// File: rtl/nand_cycle_sync.sv
module nand_cycle_sync #(
   parameter int WIDTH  = 13,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   input  logic [WIDTH-1:0] rst_val,
   output logic [WIDTH-1:0] d_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("nand_cycle_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= rst_val;
         else        chain[s] <= (s == 0) ? d_async : chain[(s == 0) ? 0 : s-1];
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/nand_cycle_decode.sv
module nand_cycle_decode
   import nand_cycle_pkg::*;
#(
   parameter int ADDR_CYCLES = 4,
   localparam int ADDR_W     = ADDR_CYCLES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              cmd_lat,
   input  logic              adr_lat,
   input  logic              wstb_n,
   input  logic              rstb_n,
   input  logic [7:0]        io_s,
   output logic [7:0]        cmd_byte,
   output logic              cmd_stb,
   output logic [ADDR_W-1:0] addr_word,
   output logic              addr_done,
   output logic [7:0]        din_byte,
   output logic              din_stb,
   output logic              bus_err,
   output logic              rd_en,
   output logic              rd_adv
);
   localparam int CNT_W = $clog2(ADDR_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(ADDR_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_CYCLES - 1);

   logic             wstb_q, rstb_q;
   logic             w_rise, r_rise;
   logic [CNT_W-1:0] acnt;
   cyc_kind_t        kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wstb_q <= 1'b1;
         rstb_q <= 1'b1;
      end else begin
         wstb_q <= wstb_n;
         rstb_q <= rstb_n;
      end
   end

   assign w_rise = wstb_n & ~wstb_q;
   assign r_rise = rstb_n & ~rstb_q;
   assign kind   = classify(sel_n, cmd_lat, adr_lat, rstb_n);
   assign rd_en  = ~sel_n & wstb_n & ~cmd_lat & ~adr_lat & ~rstb_n;
   assign rd_adv = r_rise & ~sel_n & wstb_n & ~cmd_lat & ~adr_lat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_byte  <= '0;
         cmd_stb   <= 1'b0;
         addr_word <= '0;
         addr_done <= 1'b0;
         din_byte  <= '0;
         din_stb   <= 1'b0;
         bus_err   <= 1'b0;
         acnt      <= '0;
      end else begin
         cmd_stb   <= 1'b0;
         addr_done <= 1'b0;
         din_stb   <= 1'b0;
         if (w_rise) begin
            unique case (kind)
               CYC_CMD: begin
                  cmd_byte  <= io_s;
                  cmd_stb   <= 1'b1;
                  addr_word <= '0;
                  acnt      <= '0;
               end
               CYC_ADDR: begin
                  if (acnt < CNT_MAX) begin
                     addr_word[int'(acnt)*8 +: 8] <= io_s;
                     acnt <= acnt + 1'b1;
                     if (acnt == CNT_LAST) addr_done <= 1'b1;
                  end
               end
               CYC_DIN: begin
                  din_byte <= io_s;
                  din_stb  <= 1'b1;
               end
               CYC_BAD:  bus_err <= 1'b1;
               default:  ;
            endcase
         end
      end
   end

   // R3
   acnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acnt <= CNT_MAX);

   // R5
   cmd_restarts_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> (acnt == '0 && addr_word == '0));

   // R10
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> bus_err);

   // R1
   one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_stb, addr_done, din_stb}));
endmodule

// File: rtl/nand_cycle_pagebuf.sv
module nand_cycle_pagebuf #(
   parameter int PAGE_BYTES = 64,
   localparam int COL_W     = $clog2(PAGE_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [COL_W-1:0] load_col,
   input  logic             wr_en,
   input  logic [7:0]       wr_byte,
   input  logic             rd_adv,
   input  logic             rd_en,
   output logic [7:0]       io_out,
   output logic             io_oe
);
   localparam bit POW2 = (PAGE_BYTES & (PAGE_BYTES - 1)) == 0;

   logic [7:0]       mem [PAGE_BYTES];
   logic [COL_W-1:0] wptr, rptr, w_nxt, r_nxt;

   if (POW2) begin : g_wrap_free
      assign w_nxt = wptr + 1'b1;
      assign r_nxt = rptr + 1'b1;
   end else begin : g_wrap_cmp
      assign w_nxt = (wptr == COL_W'(PAGE_BYTES - 1)) ? '0 : wptr + 1'b1;
      assign r_nxt = (rptr == COL_W'(PAGE_BYTES - 1)) ? '0 : rptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr] <= wr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr   <= '0;
         rptr   <= '0;
         io_out <= '0;
         io_oe  <= 1'b0;
      end else begin
         if (load)        wptr <= load_col;
         else if (wr_en)  wptr <= w_nxt;
         if (load)        rptr <= load_col;
         else if (rd_adv) rptr <= r_nxt;
         io_out <= mem[rptr];
         io_oe  <= rd_en;
      end
   end

   // R7
   cols_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (wptr == rptr));

   // R6
   wcol_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !load) |=> (wptr != $past(wptr)));

   // R8
   oe_idle_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !rd_en);
endmodule

// File: rtl/nand_cycle_front.sv
module nand_cycle_front
   import nand_cycle_pkg::*;
#(
   parameter int ADDR_CYCLES = 4,
   parameter int PAGE_BYTES  = 64,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = ADDR_CYCLES * 8,
   localparam int COL_W      = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_n,
   input  logic              bus_cmd_lat,
   input  logic              bus_adr_lat,
   input  logic              bus_wstb_n,
   input  logic              bus_rstb_n,
   input  logic [7:0]        io_in,
   output logic [7:0]        io_out,
   output logic              io_oe,
   output logic [7:0]        cmd_byte,
   output logic              cmd_stb,
   output logic [ADDR_W-1:0] addr_word,
   output logic              addr_done,
   output logic [7:0]        wr_data,
   output logic              wr_stb,
   output logic              bus_err
);
   if (ADDR_CYCLES < 2 || ADDR_CYCLES > 4) begin : g_bad_acyc
      $error("nand_cycle_front: ADDR_CYCLES must be 2..4");
   end
   if (PAGE_BYTES < 2 || PAGE_BYTES > 4096) begin : g_bad_page
      $error("nand_cycle_front: PAGE_BYTES must be 2..4096");
   end

   localparam int SW = 13;

   logic [SW-1:0]    pins_s;
   logic             sel_s, cl_s, al_s, ws_s, rs_s;
   logic [7:0]       io_s;
   logic             rd_en, rd_adv;
   logic [COL_W-1:0] load_col;

   nand_cycle_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({bus_sel_n, bus_cmd_lat, bus_adr_lat, bus_wstb_n, bus_rstb_n, io_in}),
      .rst_val ({1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00}),
      .d_sync  (pins_s)
   );

   assign {sel_s, cl_s, al_s, ws_s, rs_s, io_s} = pins_s;

   nand_cycle_decode #(.ADDR_CYCLES(ADDR_CYCLES)) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_n     (sel_s),
      .cmd_lat   (cl_s),
      .adr_lat   (al_s),
      .wstb_n    (ws_s),
      .rstb_n    (rs_s),
      .io_s      (io_s),
      .cmd_byte  (cmd_byte),
      .cmd_stb   (cmd_stb),
      .addr_word (addr_word),
      .addr_done (addr_done),
      .din_byte  (wr_data),
      .din_stb   (wr_stb),
      .bus_err   (bus_err),
      .rd_en     (rd_en),
      .rd_adv    (rd_adv)
   );

   assign load_col = COL_W'(addr_word[15:0] % 16'(PAGE_BYTES));

   nand_cycle_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_pagebuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (addr_done),
      .load_col (load_col),
      .wr_en    (wr_stb),
      .wr_byte  (wr_data),
      .rd_adv   (rd_adv),
      .rd_en    (rd_en),
      .io_out   (io_out),
      .io_oe    (io_oe)
   );
endmodule

// File: tb/nand_cycle_front_bench.sv
module nand_cycle_front_bench;
   localparam int PAGE = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel_n = 1'b1, cl = 1'b0, al = 1'b0, ws_n = 1'b1, rs_n = 1'b1;
   logic [7:0]  io_in = '0;
   logic [7:0]  io_out, cmd_byte, wr_data;
   logic        io_oe, cmd_stb, addr_done, wr_stb, bus_err;
   logic [31:0] addr_word;

   int n_chk = 0, n_bad = 0;
   int n_cmd = 0, n_adr = 0, n_din = 0;
   logic [7:0] exp_mem [PAGE];

   always #5 clk = ~clk;

   nand_cycle_front #(.PAGE_BYTES(PAGE)) u_nand_cycle_front (
      .clk(clk), .rst_n(rst_n), .bus_sel_n(sel_n), .bus_cmd_lat(cl),
      .bus_adr_lat(al), .bus_wstb_n(ws_n), .bus_rstb_n(rs_n), .io_in(io_in),
      .io_out(io_out), .io_oe(io_oe), .cmd_byte(cmd_byte), .cmd_stb(cmd_stb),
      .addr_word(addr_word), .addr_done(addr_done), .wr_data(wr_data),
      .wr_stb(wr_stb), .bus_err(bus_err)
   );

   always @(posedge clk) begin
      if (rst_n && cmd_stb)   n_cmd++;
      if (rst_n && addr_done) n_adr++;
      if (rst_n && wr_stb)    n_din++;
   end

   function automatic int exp_col(input logic [7:0] b0, input logic [7:0] b1);
      return int'({b1, b0}) % PAGE;
   endfunction

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic c, input logic a, input logic [7:0] d);
      @(negedge clk);
      sel_n = 1'b0; cl = c; al = a; rs_n = 1'b1; io_in = d;
      hold(4); ws_n = 1'b0; hold(4); ws_n = 1'b1; hold(5);
      cl = 1'b0; al = 1'b0; hold(1);
   endtask

   task automatic send_addr(input logic [15:0] col, input logic [15:0] row);
      bus_write(1'b0, 1'b1, col[7:0]);
      bus_write(1'b0, 1'b1, col[15:8]);
      bus_write(1'b0, 1'b1, row[7:0]);
      bus_write(1'b0, 1'b1, row[15:8]);
   endtask

   task automatic bus_read(output logic [7:0] got, output logic oe);
      @(negedge clk);
      sel_n = 1'b0; cl = 1'b0; al = 1'b0; ws_n = 1'b1; hold(1);
      rs_n = 1'b0; hold(5);
      got = io_out; oe = io_oe;
      rs_n = 1'b1; hold(5);
   endtask

   task automatic write_run(input int col, input int len);
      logic [7:0] d;
      bus_write(1'b1, 1'b0, 8'h80);
      send_addr(16'(col), 16'h0012);
      for (int i = 0; i < len; i++) begin
         d = 8'($urandom);
         bus_write(1'b0, 1'b0, d);
         exp_mem[(col + i) % PAGE] = d;
         check("R6 wr_data", 32'(wr_data), 32'(d));
      end
   endtask

   task automatic read_run(input int col, input int len, input string req);
      logic [7:0] got;
      logic       oe;
      bus_write(1'b1, 1'b0, 8'h00);
      send_addr(16'(col), 16'h0012);
      for (int i = 0; i < len; i++) begin
         bus_read(got, oe);
         check(req, 32'(got), 32'(exp_mem[(col + i) % PAGE]));
         check("R8 oe during read", 32'(oe), 32'd1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
   end

   initial begin
      logic [7:0]  b0, b1, b2, b3, keep_cmd, got;
      logic [31:0] keep_addr;
      int          base, d_before, c_before;
      logic        oe;

      void'($urandom(32'h0000_5A17));
      hold(5); rst_n = 1'b1; hold(3);

      // reset state
      check("R8 reset oe", 32'(io_oe), 32'd0);
      check("R10 reset err", 32'(bus_err), 32'd0);
      check("R3 reset addr", addr_word, 32'd0);

      // R1 command capture
      bus_write(1'b1, 1'b0, 8'h80);
      check("R1 cmd_byte", 32'(cmd_byte), 32'h80);
      check("R1 cmd_stb count", 32'(n_cmd), 32'd1);

      // R2 R3 four address bytes, lowest first
      b0 = 8'($urandom); b1 = 8'($urandom); b2 = 8'($urandom); b3 = 8'($urandom);
      bus_write(1'b0, 1'b1, b0);
      check("R2 first byte", addr_word, {24'h0, b0});
      bus_write(1'b0, 1'b1, b1);
      bus_write(1'b0, 1'b1, b2);
      check("R3 no done yet", 32'(n_adr), 32'd0);
      bus_write(1'b0, 1'b1, b3);
      check("R3 addr_word", addr_word, {b3, b2, b1, b0});
      check("R3 done count", 32'(n_adr), 32'd1);

      // R4 fifth byte ignored
      bus_write(1'b0, 1'b1, ~b0);
      check("R4 addr unchanged", addr_word, {b3, b2, b1, b0});
      check("R4 no extra done", 32'(n_adr), 32'd1);

      // R5 command clears address and count
      bus_write(1'b1, 1'b0, 8'h05);
      check("R5 addr cleared", addr_word, 32'd0);
      bus_write(1'b0, 1'b1, 8'hA1);
      bus_write(1'b0, 1'b1, 8'h3C);
      check("R5 restart at byte 0", addr_word, 32'h0000_3CA1);

      // R6 R7 directed write and readback
      base = exp_col(8'h05, 8'h00);
      d_before = n_din;
      write_run(base, 6);
      check("R6 wr_stb count", 32'(n_din - d_before), 32'd6);
      read_run(base, 6, "R7 readback");

      // R9 wrap at the page end
      write_run(PAGE - 1, 3);
      read_run(PAGE - 1, 3, "R9 wrap readback");

      // R7 random runs at random columns
      for (int r = 0; r < 5; r++) begin
         b0 = 8'($urandom); b1 = 8'($urandom);
         base = exp_col(b0, b1);
         write_run(base, 1 + int'($urandom % 6));
         read_run(base, 2, "R7 random readback");
      end

      // R8 read strobe high while selected: no drive
      @(negedge clk); sel_n = 1'b0; cl = 1'b0; al = 1'b0; ws_n = 1'b1; rs_n = 1'b1;
      hold(5);
      check("R8 oe with strobe high", 32'(io_oe), 32'd0);

      // R10 illegal latch combination
      keep_cmd = cmd_byte; keep_addr = addr_word; c_before = n_cmd;
      bus_write(1'b1, 1'b1, 8'h5A);
      check("R10 err set", 32'(bus_err), 32'd1);
      check("R10 cmd unchanged", 32'(cmd_byte), 32'(keep_cmd));
      check("R10 addr unchanged", keep_addr, addr_word);
      check("R10 no strobe", 32'(n_cmd), 32'(c_before));
      bus_write(1'b1, 1'b0, 8'h70);
      check("R10 err stays", 32'(bus_err), 32'd1);

      // R11 deselected write strobe ignored
      keep_cmd = cmd_byte; c_before = n_cmd;
      @(negedge clk); sel_n = 1'b1; cl = 1'b1; al = 1'b0; io_in = 8'hEE;
      hold(4); ws_n = 1'b0; hold(4); ws_n = 1'b1; hold(5);
      check("R11 cmd unchanged", 32'(cmd_byte), 32'(keep_cmd));
      check("R11 no strobe", 32'(n_cmd), 32'(c_before));
      cl = 1'b0;

      // R8 deselected with read strobe low: no drive
      rs_n = 1'b0; hold(5);
      check("R8 oe when deselected", 32'(io_oe), 32'd0);
      rs_n = 1'b1; hold(3);

      // R7 read still works after the above
      bus_read(got, oe);
      check("R8 oe after reselect", 32'(oe), 32'd1);

      report();
   end
endmodule